// File: doc/BRIEF.md
# Four-Pair Complementary PWM Generator with Dead Band

The block drives four pairs of complementary pulse-width-modulated outputs, one high-side and one low-side pin per pair. Every pair owns a private timebase counter, its own period and duty word, and an alignment select. An edge-aligned pair counts upward from zero to its period and restarts. A center-aligned pair counts up to its period and then back down to zero. The high side is asserted while the count is below the duty word. The low side is its complement.

A single dead-band value, in clock cycles, is shared by all pairs. Whenever either output of a pair would switch on, it is held off for that many cycles after its partner has switched off. Both pins of a pair are therefore never on together. Software may rewrite the period, duty and alignment of a pair at any time. The new words are captured into a shadow stage and replace the active ones only when the pair's counter returns to zero. A cycle in progress is never cut short or stretched.

Top module: `cpwm_quad`

## Requirements
- R1: Within a pair, the high-side and low-side outputs are never high in the same cycle.
- R2: In edge-aligned mode (align bit 0) with period P and duty D (0 < D < P), the high side rises every P+1 cycles. It stays high for D cycles when the dead band is 0, and the low side is high for the remaining P+1-D cycles.
- R3: In center-aligned mode (align bit 1) with period P and duty D (0 < D < P), the pattern repeats every 2·P cycles. The high side is high for 2·D-1 cycles of each repetition when the dead band is 0.
- R4: With a dead-band value N > 0, every gap in which both outputs of a running pair are low lasts exactly N cycles, and each on-time shrinks by N. With N = 0 there is no such gap.
- R5: A duty of 0 keeps the high side low and the low side continuously high.
- R6: A duty at or above the period (and nonzero) keeps the high side continuously high and the low side low. No dead-band gaps appear once the pair has settled.
- R7: A new period, duty or alignment written to a pair takes effect only when that pair's counter next reaches zero, so the repetition in progress completes at its old length.
- R8: Each pair runs from its own settings; pairs with different periods and duties produce their own independent waveforms at the same time.
- R9: While reset (active low) is asserted, all eight outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| center_i | input | NUM_PAIRS | Alignment per pair: 0 edge, 1 center |
| period_i | input | NUM_PAIRS*CNT_W | Period words, pair k in bits [k*CNT_W +: CNT_W] |
| duty_i | input | NUM_PAIRS*CNT_W | Duty words, same packing as period_i |
| dead_i | input | DT_W | Dead-band length in clock cycles, shared |
| pwm_hi_o | output | NUM_PAIRS | High-side outputs, bit k for pair k |
| pwm_lo_o | output | NUM_PAIRS | Low-side outputs, bit k for pair k |

## Verification
The bench builds the block with its defaults: four pairs, 14-bit counters, an 8-bit dead band and the dead-band stage present. It gives the pairs small, distinct periods, so that one edge-aligned pair, one pair with a longer period, one center-aligned pair and one pair at zero duty all run together and settle within a few hundred cycles. Because the periods are short, the bench can count many whole repetitions and derive exact on-times, gap lengths and rise spacing. It can also move a pair into the saturated-duty state and change a period in the middle of a repetition to observe the shadow load.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
   typedef enum logic {
      ALIGN_EDGE   = 1'b0,
      ALIGN_CENTER = 1'b1
   } align_e;
endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
   import cpwm_pkg::*;
#(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             center_i,
   input  logic [CNT_W-1:0] per_i,
   input  logic [CNT_W-1:0] duty_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] per_o,
   output logic [CNT_W-1:0] duty_o
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W-1:0] per_q, duty_q;
   align_e           mode_q;
   logic             down_q, down_d;
   logic             load;

   always_comb begin
      cnt_d  = cnt_q + ONE;
      down_d = down_q;
      load   = 1'b0;
      if (mode_q == ALIGN_EDGE) begin
         if (cnt_q >= per_q) begin
            cnt_d = '0;
            load  = 1'b1;
         end
      end else if (!down_q) begin
         if (per_q == '0 || (cnt_q >= per_q && cnt_q <= ONE)) begin
            cnt_d  = '0;
            load   = 1'b1;
            down_d = 1'b0;
         end else if (cnt_q >= per_q) begin
            cnt_d  = cnt_q - ONE;
            down_d = 1'b1;
         end
      end else begin
         if (cnt_q <= ONE) begin
            cnt_d  = '0;
            load   = 1'b1;
            down_d = 1'b0;
         end else begin
            cnt_d = cnt_q - ONE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         down_q <= 1'b0;
         per_q  <= '0;
         duty_q <= '0;
         mode_q <= ALIGN_EDGE;
      end else begin
         cnt_q  <= cnt_d;
         down_q <= down_d;
         if (load) begin
            per_q  <= per_i;
            duty_q <= duty_i;
            mode_q <= align_e'(center_i);
            down_q <= 1'b0;
         end
      end
   end

   assign cnt_o  = cnt_q;
   assign per_o  = per_q;
   assign duty_o = duty_q;

   // R7: the count never passes the active period
   assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= per_q);
   // R7: active words only change on the zero point
   assert_shadow_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(per_q) || !$stable(duty_q)) |-> cnt_q == '0);
endmodule

// File: rtl/cpwm_compare.sv
module cpwm_compare #(
   parameter int CNT_W = 14
) (
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] per_i,
   input  logic [CNT_W-1:0] duty_i,
   output logic             raw_o,
   output logic             full_o
);
   logic zero;

   always_comb begin
      zero   = (duty_i == '0);
      full_o = !zero && (duty_i >= per_i);
      if (zero)
         raw_o = 1'b0;
      else if (full_o)
         raw_o = 1'b1;
      else
         raw_o = (cnt_i < duty_i);
   end
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
   parameter int DT_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            raw_i,
   input  logic [DT_W-1:0] dead_i,
   output logic            hi_o,
   output logic            lo_o
);
   localparam logic [DT_W-1:0] ONE = {{(DT_W-1){1'b0}}, 1'b1};

   logic            raw_q;
   logic [DT_W-1:0] tmr_q;
   logic            hi_q, lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= 1'b0;
         tmr_q <= '0;
         hi_q  <= 1'b0;
         lo_q  <= 1'b0;
      end else if (raw_i != raw_q) begin
         raw_q <= raw_i;
         tmr_q <= dead_i;
         if (dead_i == '0) begin
            hi_q <= raw_i;
            lo_q <= !raw_i;
         end else begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
         end
      end else if (tmr_q != '0) begin
         tmr_q <= tmr_q - ONE;
         if (tmr_q == ONE) begin
            hi_q <= raw_q;
            lo_q <= !raw_q;
         end else begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
         end
      end else begin
         hi_q <= raw_q;
         lo_q <= !raw_q;
      end
   end

   assign hi_o = hi_q;
   assign lo_o = lo_q;

   // gap length tracker for the dead-band check
   logic [DT_W-1:0] gap_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gap_q <= '0;
      else if (!hi_q && !lo_q)
         gap_q <= (gap_q == '1) ? gap_q : gap_q + ONE;
      else
         gap_q <= '0;
   end

   // R1: complementary outputs never overlap
   assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_q && lo_q));
   // R4: a turn-on is preceded by at least the dead-band gap
   assert_gap_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hi_q) && $stable(dead_i)) |-> gap_q >= dead_i);
   assert_gap_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(lo_q) && $stable(dead_i) && $past(raw_q) == raw_q && raw_q == 1'b0 && $past(tmr_q) == ONE)
      |-> gap_q >= dead_i);
endmodule

// File: rtl/cpwm_quad.sv
module cpwm_quad #(
   parameter int NUM_PAIRS = 4,
   parameter int CNT_W     = 14,
   parameter int DT_W      = 8,
   parameter bit DEAD_EN   = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_PAIRS-1:0]       center_i,
   input  logic [NUM_PAIRS*CNT_W-1:0] period_i,
   input  logic [NUM_PAIRS*CNT_W-1:0] duty_i,
   input  logic [DT_W-1:0]            dead_i,
   output logic [NUM_PAIRS-1:0]       pwm_hi_o,
   output logic [NUM_PAIRS-1:0]       pwm_lo_o
);
   if (NUM_PAIRS < 1) begin : g_chk_pairs
      $error("cpwm_quad: NUM_PAIRS must be at least 1");
   end
   if (CNT_W < 2 || CNT_W > 16) begin : g_chk_cnt
      $error("cpwm_quad: CNT_W must lie in 2..16");
   end
   if (DT_W < 1 || DT_W > 16) begin : g_chk_dt
      $error("cpwm_quad: DT_W must lie in 1..16");
   end

   for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
      logic [CNT_W-1:0] cnt, per_a, duty_a;
      logic             raw, full;

      cpwm_timebase #(.CNT_W(CNT_W)) u_tb (
         .clk      (clk),
         .rst_n    (rst_n),
         .center_i (center_i[k]),
         .per_i    (period_i[k*CNT_W +: CNT_W]),
         .duty_i   (duty_i[k*CNT_W +: CNT_W]),
         .cnt_o    (cnt),
         .per_o    (per_a),
         .duty_o   (duty_a)
      );

      cpwm_compare #(.CNT_W(CNT_W)) u_cmp (
         .cnt_i  (cnt),
         .per_i  (per_a),
         .duty_i (duty_a),
         .raw_o  (raw),
         .full_o (full)
      );

      if (DEAD_EN) begin : g_db
         cpwm_deadband #(.DT_W(DT_W)) u_db (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw),
            .dead_i (dead_i),
            .hi_o   (pwm_hi_o[k]),
            .lo_o   (pwm_lo_o[k])
         );
      end else begin : g_nodb
         logic hi_q, lo_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hi_q <= 1'b0;
               lo_q <= 1'b0;
            end else begin
               hi_q <= raw;
               lo_q <= !raw;
            end
         end
         assign pwm_hi_o[k] = hi_q;
         assign pwm_lo_o[k] = lo_q;
      end

      // R6: a saturated duty keeps the low side off
      assert_full_lo_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(full) && full) |-> !pwm_lo_o[k]);
      // R5: zero duty keeps the high side off
      assert_zero_hi_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(duty_a) == '0 && duty_a == '0) |-> !pwm_hi_o[k]);
   end
endmodule

// File: tb/cpwm_quad_test.sv
module cpwm_quad_test;
   localparam int NP = 4;
   localparam int CW = 14;
   localparam int DW = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NP-1:0]     center;
   logic [NP*CW-1:0]  period;
   logic [NP*CW-1:0]  duty;
   logic [DW-1:0]     dead;
   logic [NP-1:0]     pwm_hi, pwm_lo;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   cpwm_quad #(.NUM_PAIRS(NP), .CNT_W(CW), .DT_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .center_i(center), .period_i(period),
      .duty_i(duty), .dead_i(dead), .pwm_hi_o(pwm_hi), .pwm_lo_o(pwm_lo)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic set_pair(input int p, input bit c, input int per, input int d);
      center[p] = c;
      period[p*CW +: CW] = CW'(per);
      duty[p*CW +: CW] = CW'(d);
   endtask

   task automatic measure(input int p, input int n,
                          output int hi_n, output int lo_n, output int bh, output int bl,
                          output int gmin, output int gmax, output int rmin, output int rmax);
      int run = 0;
      bit seen = 0;
      int last = -1;
      bit prev;
      hi_n = 0; lo_n = 0; bh = 0; bl = 0;
      gmin = 9999; gmax = 0; rmin = 9999; rmax = 0;
      @(negedge clk);
      prev = pwm_hi[p];
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (pwm_hi[p]) hi_n++;
         if (pwm_lo[p]) lo_n++;
         if (pwm_hi[p] && pwm_lo[p]) bh++;
         if (!pwm_hi[p] && !pwm_lo[p]) begin
            bl++;
            run++;
         end else begin
            if (seen && run > 0) begin
               if (run < gmin) gmin = run;
               if (run > gmax) gmax = run;
            end
            run = 0;
            seen = 1;
         end
         if (pwm_hi[p] && !prev) begin
            if (last >= 0) begin
               if (i - last < rmin) rmin = i - last;
               if (i - last > rmax) rmax = i - last;
            end
            last = i;
         end
         prev = pwm_hi[p];
      end
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R9", "high sides in reset", int'(pwm_hi), 0);
      chk("R9", "low sides in reset", int'(pwm_lo), 0);
      rst_n = 1'b1;
   endtask

   task automatic t_edge();
      int h, l, bh, bl, g0, g1, r0, r1;
      repeat (60) @(negedge clk);
      measure(0, 100, h, l, bh, bl, g0, g1, r0, r1);
      chk("R2", "pair0 high time", h, 40);
      chk("R2", "pair0 low time", l, 60);
      chk("R2", "pair0 rise spacing min", r0, 10);
      chk("R2", "pair0 rise spacing max", r1, 10);
      chk("R1", "pair0 overlap", bh, 0);
      chk("R4", "pair0 gap cycles at zero dead band", bl, 0);
      measure(1, 200, h, l, bh, bl, g0, g1, r0, r1);
      chk("R8", "pair1 high time", h, 100);
      chk("R8", "pair1 rise spacing", r1, 20);
   endtask

   task automatic t_center();
      int h, l, bh, bl, g0, g1, r0, r1;
      measure(2, 160, h, l, bh, bl, g0, g1, r0, r1);
      chk("R3", "pair2 high time", h, 50);
      chk("R3", "pair2 low time", l, 110);
      chk("R3", "pair2 rise spacing min", r0, 16);
      chk("R3", "pair2 rise spacing max", r1, 16);
   endtask

   task automatic t_zero();
      int h, l, bh, bl, g0, g1, r0, r1;
      measure(3, 60, h, l, bh, bl, g0, g1, r0, r1);
      chk("R5", "pair3 high time", h, 0);
      chk("R5", "pair3 low time", l, 60);
   endtask

   task automatic t_dead();
      int h, l, bh, bl, g0, g1, r0, r1;
      dead = 8'd2;
      repeat (50) @(negedge clk);
      measure(0, 100, h, l, bh, bl, g0, g1, r0, r1);
      chk("R4", "pair0 high time with dead band", h, 20);
      chk("R4", "pair0 low time with dead band", l, 40);
      chk("R4", "pair0 shortest gap", g0, 2);
      chk("R4", "pair0 longest gap", g1, 2);
      chk("R1", "pair0 overlap with dead band", bh, 0);
      measure(2, 160, h, l, bh, bl, g0, g1, r0, r1);
      chk("R4", "pair2 center high time with dead band", h, 30);
      chk("R4", "pair2 center gap", g1, 2);
      measure(3, 60, h, l, bh, bl, g0, g1, r0, r1);
      chk("R5", "pair3 low stays high with dead band", l, 60);
   endtask

   task automatic t_full();
      int h, l, bh, bl, g0, g1, r0, r1;
      set_pair(1, 1'b0, 19, 20);
      repeat (80) @(negedge clk);
      measure(1, 100, h, l, bh, bl, g0, g1, r0, r1);
      chk("R6", "pair1 saturated high time", h, 100);
      chk("R6", "pair1 saturated low time", l, 0);
      chk("R6", "pair1 saturated gap cycles", bl, 0);
   endtask

   task automatic t_update();
      int t = 0;
      int last = -1;
      int iv[2];
      int nv = 0;
      bit prev;
      dead = 8'd0;
      repeat (40) @(negedge clk);
      prev = pwm_hi[0];
      while (nv < 2 && t < 200) begin
         @(negedge clk);
         t++;
         if (last >= 0 && t - last == 3 && nv == 0) set_pair(0, 1'b0, 14, 4);
         if (pwm_hi[0] && !prev) begin
            if (last >= 0) begin
               iv[nv] = t - last;
               nv++;
            end
            last = t;
         end
         prev = pwm_hi[0];
      end
      chk("R7", "interval holding the rewrite", iv[0], 10);
      chk("R7", "interval after the rewrite", iv[1], 15);
   endtask

   initial begin
      center = '0; period = '0; duty = '0; dead = '0;
      set_pair(0, 1'b0, 9, 4);
      set_pair(1, 1'b0, 19, 10);
      set_pair(2, 1'b1, 8, 3);
      set_pair(3, 1'b0, 5, 0);
      t_reset();
      t_edge();
      t_center();
      t_zero();
      t_dead();
      t_full();
      t_update();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule